// File: doc/BRIEF.md
# Micro-op Cache Mode Controller

This block sits in an instruction front end and decides, loop by loop, whether instructions are supplied by the normal instruction cache and decoders or only by a micro-op cache. It watches the stream of edge lookups coming from a small loop predictor. Each edge has a "built" bit, which records whether the target basic block is already held in the micro-op cache. The block walks a three-mode machine: filter (qualify the code), build (fill the micro-op cache) and fetch (stream from the micro-op cache with the instruction cache and decoders switched off).

Built status is not checked at prediction time. When the micro-op cache's tag check finds a requested block already resident, that fact is sent back and the edge's built bit is set. In build and fetch mode the block keeps two saturating counts: lookups that hit built edges and lookups that hit unbuilt edges. Mode changes come from comparing these two counts against ratio thresholds, and the comparison uses constant shifts instead of a divider. A build timer bounds how long build mode may last. A mispredict or flush returns the block to filter mode.

Lookups arrive on a valid/ready stream. Allocation requests leave on a valid/ready stream with a single registered slot. While that slot holds a request the cache has not accepted, lookup ready is low. The mode, the instruction-cache/decoder enable, flush and tag feedback are plain signals.

Top module: `uopc_mode_ctrl`

## Requirements
- R1: After reset, mode is filter, icache_en is 1, alloc_valid and bset_valid are 0, and every built bit is clear. The mode encoding is 0 = filter, 1 = build, 2 = fetch.
- R2: In filter mode, an accepted lookup with lk_qual=1 moves the mode to build on the next cycle. A lookup with lk_qual=0 leaves the mode at filter and raises no allocation.
- R3: Built bits are cleared only by reset. A flush or a mode change leaves them unchanged.
- R4: In build mode, each accepted lookup advances the build timer. An unbuilt edge increments the build count and presents an allocation request carrying that edge on the next cycle. A built edge increments the fetch count and requests nothing. No allocation request is ever raised in filter or fetch mode.
- R5: A tag feedback with tag_hit=1 sets that edge's built bit and pulses bset_valid with bset_edge equal to that edge on the next cycle. If a request for the same edge is waiting unaccepted in the allocation slot, it is withdrawn.
- R6: In build mode, the mode becomes fetch on the next cycle when, after the update, the fetch count is non-zero and is at least the build count times 2^ENTER_SHIFT (4 by default). This check takes priority over the timeout.
- R7: In fetch mode, icache_en is 0, and accepted lookups still update the built and unbuilt counts.
- R8: In fetch mode, the mode returns to filter and both counts clear when, after the update, the build count is non-zero and the build count times 2^EXIT_SHIFT (2 by default) is at least the fetch count.
- R9: If the BUILD_TIMEOUT-th build-mode lookup (16 by default) does not meet R6, the mode returns to filter and the counts clear.
- R10: flush=1 forces filter mode on the next cycle, clears both counts and the timer, discards any held allocation request, and discards a lookup presented in the same cycle.
- R11: While alloc_valid=1 and alloc_ready=0, lk_ready is 0, no lookup is accepted, and alloc_edge holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_ready | output | 1 | Lookup accepted when high with lk_valid |
| lk_edge | input | IDX_W | Predictor edge index of the lookup |
| lk_qual | input | 1 | Segment is predictable and fits both structures |
| tag_valid | input | 1 | Tag feedback present |
| tag_edge | input | IDX_W | Edge the feedback refers to |
| tag_hit | input | 1 | Block already resident in the micro-op cache |
| flush | input | 1 | Mispredict or pipeline flush |
| mode | output | 2 | Current mode (0 filter, 1 build, 2 fetch) |
| icache_en | output | 1 | Instruction cache and decoder enable |
| alloc_valid | output | 1 | Allocation request present |
| alloc_ready | input | 1 | Micro-op cache takes the request |
| alloc_edge | output | IDX_W | Edge whose target block should be allocated |
| bset_valid | output | 1 | Built-bit set event |
| bset_edge | output | IDX_W | Edge whose built bit was set |

## Verification
The first build phase drives only unbuilt edges, then only edges whose built bits were set through tag feedback. This separates the allocation path from the fetch-count path and finds the exact lookup at which the 4:1 entry ratio is met. Once in fetch mode, a run of unbuilt edges separates the exit threshold from the entry threshold: three of them keep fetch mode and the fourth leaves it, and none of them allocates. A build phase made only of unbuilt edges reaches the timeout and separates it from the ratio exit. A single built lookup right after a flush can only reach fetch mode if the counts were cleared and the built bits kept. Holding alloc_ready low while lookups and a matching tag hit arrive shows both the stall and the withdrawal of a redundant request.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
  typedef enum logic [1:0] {
    MODE_FILTER = 2'd0,
    MODE_BUILD  = 2'd1,
    MODE_FETCH  = 2'd2
  } uopc_mode_e;
endpackage

// File: rtl/uopc_built_array.sv
// Per-edge built bits: one synchronous-set flop per edge, cleared by reset only.
module uopc_built_array #(
  parameter int EDGES = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx
);
  logic [EDGES-1:0] bits_q;

  for (genvar i = 0; i < EDGES; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bits_q[i] <= 1'b0;
      end else if (set_en && (set_idx == IDX_W'(i))) begin
        bits_q[i] <= 1'b1;
      end
    end
  end

  assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/uopc_edge_counters.sv
// Saturating built/unbuilt lookup counts and the build timer.
// The *_nx outputs are the post-update values used for the mode decision.
module uopc_edge_counters #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bump_en,
  input  logic             bump_built,
  input  logic             tmr_en,
  output logic [CNT_W-1:0] bcnt_nx,
  output logic [CNT_W-1:0] fcnt_nx,
  output logic [TMR_W-1:0] tmr_nx
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [CNT_W-1:0] bcnt_q, fcnt_q;
  logic [TMR_W-1:0] tmr_q;

  always_comb begin
    bcnt_nx = bcnt_q;
    fcnt_nx = fcnt_q;
    tmr_nx  = tmr_q;
    if (bump_en && !bump_built && (bcnt_q != CNT_MAX)) bcnt_nx = bcnt_q + 1'b1;
    if (bump_en &&  bump_built && (fcnt_q != CNT_MAX)) fcnt_nx = fcnt_q + 1'b1;
    if (tmr_en && (tmr_q != TMR_MAX))                  tmr_nx  = tmr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bcnt_q <= '0;
      fcnt_q <= '0;
      tmr_q  <= '0;
    end else begin
      bcnt_q <= bcnt_nx;
      fcnt_q <= fcnt_nx;
      tmr_q  <= tmr_nx;
    end
  end
endmodule

// File: rtl/uopc_ratio_judge.sv
// Ratio thresholds by cross-multiplication with constant shifts.
module uopc_ratio_judge #(
  parameter int CNT_W         = 8,
  parameter int TMR_W         = 5,
  parameter int ENTER_SHIFT   = 2,
  parameter int EXIT_SHIFT    = 1,
  parameter int BUILD_TIMEOUT = 16
) (
  input  logic [CNT_W-1:0] bcnt,
  input  logic [CNT_W-1:0] fcnt,
  input  logic [TMR_W-1:0] tmr,
  output logic             go_fetch,
  output logic             go_leave,
  output logic             timed_out
);
  localparam int EN_W = CNT_W + ENTER_SHIFT;
  localparam int EX_W = CNT_W + EXIT_SHIFT;

  logic [EN_W-1:0] b_scaled_en, f_wide_en;
  logic [EX_W-1:0] b_scaled_ex, f_wide_ex;

  always_comb begin
    b_scaled_en = EN_W'(bcnt) << ENTER_SHIFT;
    f_wide_en   = EN_W'(fcnt);
    b_scaled_ex = EX_W'(bcnt) << EXIT_SHIFT;
    f_wide_ex   = EX_W'(fcnt);
  end

  assign go_fetch  = (fcnt != '0) && (f_wide_en >= b_scaled_en);
  assign go_leave  = (bcnt != '0) && (b_scaled_ex >= f_wide_ex);
  assign timed_out = (tmr == TMR_W'(BUILD_TIMEOUT));
endmodule

// File: rtl/uopc_alloc_slot.sv
// Single registered allocation request slot with valid/ready output.
module uopc_alloc_slot #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             drop_en,
  input  logic [IDX_W-1:0] drop_idx,
  input  logic             flush,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic             can_accept
);
  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic             fire, drop;

  assign fire       = valid_q && out_ready;
  assign drop       = valid_q && drop_en && (drop_idx == idx_q);
  assign can_accept = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      idx_q   <= load_idx;
    end else if (fire || drop) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_idx   = idx_q;
endmodule

// File: rtl/uopc_mode_ctrl.sv
module uopc_mode_ctrl
  import uopc_pkg::*;
#(
  parameter int EDGES         = 64,
  parameter int CNT_W         = 8,
  parameter int BUILD_TIMEOUT = 16,
  parameter int ENTER_SHIFT   = 2,
  parameter int EXIT_SHIFT    = 1,
  localparam int IDX_W        = $clog2(EDGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [IDX_W-1:0] lk_edge,
  input  logic             lk_qual,
  input  logic             tag_valid,
  input  logic [IDX_W-1:0] tag_edge,
  input  logic             tag_hit,
  input  logic             flush,
  output logic [1:0]       mode,
  output logic             icache_en,
  output logic             alloc_valid,
  input  logic             alloc_ready,
  output logic [IDX_W-1:0] alloc_edge,
  output logic             bset_valid,
  output logic [IDX_W-1:0] bset_edge
);
  localparam int TMR_W = $clog2(BUILD_TIMEOUT + 1);

  uopc_mode_e       mode_q, mode_d;
  logic             accept, edge_built, tag_set;
  logic             in_build, in_fetch, cnt_clr;
  logic [CNT_W-1:0] bcnt_nx, fcnt_nx;
  logic [TMR_W-1:0] tmr_nx;
  logic             go_fetch, go_leave, timed_out;
  logic             slot_free;
  logic             bset_q;
  logic [IDX_W-1:0] bset_idx_q;

  assign in_build = (mode_q == MODE_BUILD);
  assign in_fetch = (mode_q == MODE_FETCH);
  assign lk_ready = slot_free;
  assign accept   = lk_valid && slot_free && !flush;
  assign tag_set  = tag_valid && tag_hit;

  uopc_built_array #(.EDGES(EDGES), .IDX_W(IDX_W)) u_built (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lk_edge),
    .rd_bit (edge_built),
    .set_en (tag_set),
    .set_idx(tag_edge)
  );

  uopc_edge_counters #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .bump_en   (accept && (in_build || in_fetch)),
    .bump_built(edge_built),
    .tmr_en    (accept && in_build),
    .bcnt_nx   (bcnt_nx),
    .fcnt_nx   (fcnt_nx),
    .tmr_nx    (tmr_nx)
  );

  uopc_ratio_judge #(
    .CNT_W(CNT_W), .TMR_W(TMR_W), .ENTER_SHIFT(ENTER_SHIFT),
    .EXIT_SHIFT(EXIT_SHIFT), .BUILD_TIMEOUT(BUILD_TIMEOUT)
  ) u_judge (
    .bcnt     (bcnt_nx),
    .fcnt     (fcnt_nx),
    .tmr      (tmr_nx),
    .go_fetch (go_fetch),
    .go_leave (go_leave),
    .timed_out(timed_out)
  );

  uopc_alloc_slot #(.IDX_W(IDX_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && in_build && !edge_built),
    .load_idx  (lk_edge),
    .drop_en   (tag_set),
    .drop_idx  (tag_edge),
    .flush     (flush),
    .out_ready (alloc_ready),
    .out_valid (alloc_valid),
    .out_idx   (alloc_edge),
    .can_accept(slot_free)
  );

  // Mode sequencing; flush has top priority, fetch entry beats timeout.
  always_comb begin
    mode_d  = mode_q;
    cnt_clr = 1'b0;
    if (flush) begin
      mode_d  = MODE_FILTER;
      cnt_clr = 1'b1;
    end else if (accept) begin
      unique case (mode_q)
        MODE_FILTER: begin
          cnt_clr = 1'b1;
          if (lk_qual) mode_d = MODE_BUILD;
        end
        MODE_BUILD: begin
          if (go_fetch) begin
            mode_d = MODE_FETCH;
          end else if (timed_out) begin
            mode_d  = MODE_FILTER;
            cnt_clr = 1'b1;
          end
        end
        MODE_FETCH: begin
          if (go_leave) begin
            mode_d  = MODE_FILTER;
            cnt_clr = 1'b1;
          end
        end
        default: begin
          mode_d  = MODE_FILTER;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_FILTER;
      bset_q     <= 1'b0;
      bset_idx_q <= '0;
    end else begin
      mode_q     <= mode_d;
      bset_q     <= tag_set;
      if (tag_set) bset_idx_q <= tag_edge;
    end
  end

  assign mode       = mode_q;
  assign icache_en  = !in_fetch;
  assign bset_valid = bset_q;
  assign bset_edge  = bset_idx_q;
endmodule

// File: rtl/uopc_mode_ctrl_chk.sv
module uopc_mode_ctrl_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_qual,
  input logic             tag_valid,
  input logic [IDX_W-1:0] tag_edge,
  input logic             tag_hit,
  input logic             flush,
  input logic [1:0]       mode,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_edge,
  input logic             bset_valid
);
  logic same_hit;
  assign same_hit = tag_valid && tag_hit && (tag_edge == alloc_edge);

  AST_BUILD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && $past(mode) == 2'd0) |-> $past(lk_valid && lk_qual)); // R2

  AST_ALLOC_ONLY_BUILD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !$past(alloc_valid)) |-> $past(mode) == 2'd1); // R4

  AST_BSET_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    bset_valid |-> $past(tag_valid && tag_hit)); // R5

  AST_DROP_REDUNDANT: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && same_hit) |=> !alloc_valid); // R5

  AST_FETCH_FROM_BUILD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(mode) == 2'd1); // R6

  AST_FLUSH_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mode == 2'd0 && !alloc_valid)); // R10

  AST_ALLOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !same_hit && !flush) |=> (alloc_valid && $stable(alloc_edge))); // R11
endmodule

bind uopc_mode_ctrl uopc_mode_ctrl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/uopc_mode_ctrl_tb.sv
module uopc_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lk_valid = 1'b0, lk_ready, lk_qual = 1'b0;
  logic [5:0] lk_edge = '0;
  logic       tag_valid = 1'b0, tag_hit = 1'b0;
  logic [5:0] tag_edge = '0;
  logic       flush = 1'b0;
  logic [1:0] mode;
  logic       icache_en, alloc_valid, alloc_ready = 1'b1, bset_valid;
  logic [5:0] alloc_edge, bset_edge;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  uopc_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_edge(lk_edge), .lk_qual(lk_qual), .tag_valid(tag_valid),
    .tag_edge(tag_edge), .tag_hit(tag_hit), .flush(flush), .mode(mode),
    .icache_en(icache_en), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_edge(alloc_edge), .bset_valid(bset_valid), .bset_edge(bset_edge)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard monitor: a handshake completes at the next rising edge.
  always @(negedge clk) begin
    if (rst_n && alloc_valid && alloc_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected alloc actual=%0d expected=none", alloc_edge);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(alloc_edge) != e) begin
          fails++;
          $display("FAIL R4 alloc edge actual=%0d expected=%0d", alloc_edge, e);
        end
      end
    end
  end

  task automatic do_lk(input int e, input bit q, input bit exp_alloc);
    while (!lk_ready) begin @(posedge clk); #2; end
    lk_valid = 1'b1; lk_edge = 6'(e); lk_qual = q;
    if (exp_alloc) exp_q.push_back(e);
    @(posedge clk); #2;
    lk_valid = 1'b0; lk_qual = 1'b0;
  endtask

  task automatic do_tag(input int e, input bit hit);
    tag_valid = 1'b1; tag_edge = 6'(e); tag_hit = hit;
    @(posedge clk); #2;
    tag_valid = 1'b0; tag_hit = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(posedge clk); #2;
    flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 icache_en", icache_en, 1);
    chk("R1 alloc_valid", alloc_valid, 0);
    chk("R1 bset_valid", bset_valid, 0);
    chk("R1 lk_ready", lk_ready, 1);

    // R2 unqualified lookup stays in filter
    do_lk(7, 0, 0);
    chk("R2 no qual stays filter", mode, 0);
    @(posedge clk); #2;
    chk("R2 no alloc in filter", alloc_valid, 0);
    do_lk(7, 1, 0);
    chk("R2 qual enters build", mode, 1);

    // R4 unbuilt edges allocate (also shows R1 bits start clear)
    do_lk(3, 0, 1); do_lk(4, 0, 1); do_lk(5, 0, 1);
    chk("R4 build after unbuilt", mode, 1);
    @(posedge clk); #2;

    // R5 back-propagation
    do_tag(3, 1);
    chk("R5 bset_valid", bset_valid, 1);
    chk("R5 bset_edge", bset_edge, 3);
    do_tag(4, 1); do_tag(5, 1);
    do_tag(6, 0);
    chk("R5 miss no bset", bset_valid, 0);

    // R6 entry at 12 built vs 3 unbuilt (4:1); 11th still build
    for (int i = 0; i < 11; i++) do_lk(3 + (i % 3), 0, 0);
    chk("R6 below ratio stays build", mode, 1);
    do_lk(4, 0, 0);
    chk("R6 ratio reached fetch", mode, 2);
    chk("R7 icache off in fetch", icache_en, 0);

    // R7/R8 fetch keeps counting; exit at 2*build >= fetch
    do_lk(3, 0, 0); do_lk(5, 0, 0);
    do_lk(50, 0, 0); do_lk(51, 0, 0); do_lk(52, 0, 0);
    chk("R4 no alloc in fetch", alloc_valid, 0);
    chk("R8 below exit stays fetch", mode, 2);
    do_lk(53, 0, 0);
    chk("R8 exit to filter", mode, 0);
    chk("R8 icache back on", icache_en, 1);

    // R9 timeout with only unbuilt edges
    do_lk(9, 1, 0);
    chk("R2 reenter build", mode, 1);
    for (int i = 0; i < 15; i++) do_lk(10 + i, 0, 1);
    chk("R9 before timeout build", mode, 1);
    do_lk(25, 0, 1);
    chk("R9 timeout to filter", mode, 0);
    @(posedge clk); #2;

    // R10 flush clears counts; R3 built bits survive
    do_lk(9, 1, 0);
    do_lk(30, 0, 1); do_lk(31, 0, 1);
    do_flush();
    chk("R10 flush to filter", mode, 0);
    chk("R10 flush drops alloc", alloc_valid, 0);
    do_lk(9, 1, 0);
    do_lk(3, 0, 0);
    chk("R10 R3 counts cleared bit kept", mode, 2);

    // R11 back-pressure and R5 redundant drop
    do_flush();
    do_lk(9, 1, 0);
    alloc_ready = 1'b0;
    do_lk(40, 0, 0);
    chk("R11 alloc held", alloc_valid, 1);
    chk("R11 lk_ready low", lk_ready, 0);
    lk_valid = 1'b1; lk_edge = 6'd41; lk_qual = 1'b0;
    @(posedge clk); #2;
    @(posedge clk); #2;
    chk("R11 alloc edge stable", alloc_edge, 40);
    do_tag(40, 1);
    lk_valid = 1'b0;
    chk("R5 redundant alloc dropped", alloc_valid, 0);
    @(posedge clk); #2;
    chk("R11 stalled lookup not taken", alloc_valid, 0);
    alloc_ready = 1'b1;
    chk("R11 lk_ready restored", lk_ready, 1);

    repeat (3) @(posedge clk); #2;
    chk("R4 all expected allocs seen", exp_q.size(), 0);
    finish_up();
  end
endmodule